// File: doc/BRIEF.md
# Object Handle Hash Table Engine

This block keeps a table of 32-bit object handles in on-chip RAM and serves three commands on it: insert, remove and lookup. Every command carries a handle and a channel id; insert also carries a context word that is stored beside the handle. The table holds 2^IDX_W entries. Each entry is two 32-bit words: the handle word and the context word. The two words sit in two RAM banks that are read together, so one read returns a whole entry.

A command starts at the slot given by a folded hash of the handle. The handle is XOR-folded in IDX_W-bit chunks, and in legacy mode the channel id is mixed in as well. The engine then reads entries one at a time, moving to the next slot and wrapping from the last slot to slot 0. It stops when an insert finds a free slot, when a remove or lookup finds a live entry with the same handle, or when every slot has been visited. The result comes back as a one-cycle done pulse with a status code. A lookup that hits also returns the stored context word. After reset the engine first zeroes the whole table, and it accepts commands only while `cmd_ready` is high.

Top module: `objhash_engine`

## Requirements
- R1: After reset, `rsp_done` is low and `cmd_ready` stays low while the table is zeroed, one slot per cycle. `cmd_ready` goes high exactly 2^IDX_W cycles after reset is released, and every slot is then empty.
- R2: The start slot is computed as follows. Zero-extend the handle to a whole number of IDX_W-bit chunks and XOR all the chunks together. With LEGACY=1, also XOR in the channel id shifted left by IDX_W-4, keeping the low IDX_W bits.
- R3: Insert (`cmd_op`=2'b01) writes the handle and the context word into the first probed slot whose context bit 31 is 0. With LEGACY=1 the stored context has bit 31 forced to 1. The response has status 2'b00 and `rsp_ctx` 0.
- R4: Probing moves from slot s to slot s+1, and from the last slot to slot 0, visiting each slot at most once per command.
- R5: An insert that finds no free slot after visiting all 2^IDX_W slots ends with status 2'b10 (full) and leaves the table unchanged. Only insert can report full.
- R6: Lookup (`cmd_op`=2'b00, with 2'b11 treated the same) hits only on an entry whose context bit 31 is 1 and whose handle word equals the command handle. A hit returns the stored context and status 2'b00. A miss returns status 2'b01 and `rsp_ctx` 0 after all slots have been visited. Empty slots do not stop the probe.
- R7: Remove (`cmd_op`=2'b10) uses the same match rule as lookup. On a hit it zeroes both words of the entry and returns status 2'b00 with `rsp_ctx` 0. A later insert can reuse the freed slot, and entries beyond it stay reachable. A remove that misses returns status 2'b01.
- R8: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. If it ends after k probes, `rsp_done` is high for exactly one cycle, in the cycle starting 2k edges after acceptance. `cmd_ready` is low from acceptance until that cycle.
- R9: `cmd_valid` and the command fields are ignored while `cmd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; a command is taken this edge if cmd_valid is high |
| cmd_op | input | 2 | 00 lookup, 01 insert, 10 remove, 11 lookup |
| cmd_handle | input | 32 | Object handle |
| cmd_chan | input | CHAN_W | Channel id |
| cmd_ctx | input | 32 | Context word for insert |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | 00 ok, 01 not found, 10 full |
| rsp_ctx | output | 32 | Context word returned by a lookup hit, else 0 |

## Verification
A wrong hash or a wrong wrap changes where entries land. This shows up on the first colliding command as a wrong probe count, seen as `rsp_done` arriving at the wrong cycle, and later as lookups that miss. A bad valid or match decision shows up in the status or context of the very command that reads the entry. A leftover write from a remove or a full insert is caught by the next lookup or insert that probes that slot. The bench model predicts the exact cycle of every done pulse and compares the outputs on every clock, so a timing error is reported in the cycle it occurs.

// File: rtl/objhash_pkg.sv
package objhash_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP     = 2'b00,
    OP_INSERT     = 2'b01,
    OP_REMOVE     = 2'b10,
    OP_LOOKUP_ALT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_OK   = 2'b00,
    ST_MISS = 2'b01,
    ST_FULL = 2'b10
  } status_e;

  typedef enum logic [1:0] {
    S_CLEAR = 2'b00,
    S_IDLE  = 2'b01,
    S_READ  = 2'b10,
    S_CMP   = 2'b11
  } fsm_e;

  localparam int unsigned LIVE_BIT = 31;

endpackage

// File: rtl/objhash_bank.sv
module objhash_bank #(
  parameter int AW = 6,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Simple dual-port: one synchronous write, one registered read.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/objhash_hash.sv
module objhash_hash #(
  parameter int IDX_W    = 6,
  parameter int CHAN_W   = 5,
  parameter bit MIX_CHAN = 1'b1
) (
  input  logic [31:0]       handle,
  input  logic [CHAN_W-1:0] chan,
  output logic [IDX_W-1:0]  slot
);
  localparam int NCHUNK = (32 + IDX_W - 1) / IDX_W;
  localparam int PADW   = NCHUNK * IDX_W;
  localparam int WIDE_W = IDX_W + CHAN_W;

  logic [PADW-1:0]   padded;
  logic [IDX_W-1:0]  folded;
  logic [WIDE_W-1:0] chan_wide;
  logic [IDX_W-1:0]  chan_mix;

  always_comb begin
    padded = PADW'(handle);
    folded = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      folded = folded ^ padded[i*IDX_W +: IDX_W];
    end
  end

  generate
    if (MIX_CHAN) begin : g_mix
      assign chan_wide = WIDE_W'(chan) << (IDX_W - 4);
      assign chan_mix  = chan_wide[IDX_W-1:0];
    end else begin : g_nomix
      assign chan_wide = '0;
      assign chan_mix  = '0;
    end
  endgenerate

  assign slot = folded ^ chan_mix;
endmodule

// File: rtl/objhash_engine.sv
module objhash_engine
  import objhash_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int CHAN_W = 5,
  parameter bit LEGACY = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [31:0]       cmd_handle,
  input  logic [CHAN_W-1:0] cmd_chan,
  input  logic [31:0]       cmd_ctx,
  output logic              rsp_done,
  output logic [1:0]        rsp_status,
  output logic [31:0]       rsp_ctx
);
  localparam int SLOTS = 1 << IDX_W;
  localparam int CNT_W = IDX_W + 1;
  localparam logic [CNT_W-1:0] ALL_PROBED = CNT_W'(SLOTS);

  fsm_e              state;
  logic [1:0]        op_q;
  logic [31:0]       hdl_q;
  logic [31:0]       ctx_q;
  logic [31:0]       stored_ctx;
  logic [IDX_W-1:0]  cur_slot;
  logic [IDX_W-1:0]  clr_idx;
  logic [IDX_W-1:0]  hash_slot;
  logic [CNT_W-1:0]  probe_cnt;
  logic [CNT_W-1:0]  probe_nxt;
  logic [31:0]       rd_word [2];
  logic [31:0]       wr_word [2];
  logic              ram_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic              entry_live;
  logic              probe_hit;
  logic              op_is_insert;
  logic              op_is_lookup;

  objhash_hash #(
    .IDX_W   (IDX_W),
    .CHAN_W  (CHAN_W),
    .MIX_CHAN(LEGACY)
  ) u_hash (
    .handle(cmd_handle),
    .chan  (cmd_chan),
    .slot  (hash_slot)
  );

  // Bank 0 holds handle words, bank 1 holds context words.
  generate
    for (genvar k = 0; k < 2; k++) begin : g_bank
      objhash_bank #(
        .AW(IDX_W),
        .DW(32)
      ) u_bank (
        .clk  (clk),
        .we   (ram_we),
        .waddr(ram_waddr),
        .wdata(wr_word[k]),
        .raddr(cur_slot),
        .rdata(rd_word[k])
      );
    end
  endgenerate

  generate
    if (LEGACY) begin : g_live_flag
      assign entry_live = rd_word[1][LIVE_BIT];
      assign stored_ctx = ctx_q | (32'h1 << LIVE_BIT);
    end else begin : g_live_nonzero
      assign entry_live = |rd_word[1];
      assign stored_ctx = ctx_q;
    end
  endgenerate

  assign cmd_ready = (state == S_IDLE);

  always_comb begin
    op_is_insert = (op_q == OP_INSERT);
    op_is_lookup = (op_q == OP_LOOKUP) || (op_q == OP_LOOKUP_ALT);
    probe_hit    = op_is_insert ? !entry_live
                                : (entry_live && (rd_word[0] == hdl_q));
    probe_nxt    = probe_cnt + CNT_W'(1);
    ram_we       = 1'b0;
    ram_waddr    = cur_slot;
    wr_word[0]   = '0;
    wr_word[1]   = '0;
    if (state == S_CLEAR) begin
      ram_we    = 1'b1;
      ram_waddr = clr_idx;
    end else if (state == S_CMP && probe_hit && !op_is_lookup) begin
      ram_we = 1'b1;
      if (op_is_insert) begin
        wr_word[0] = hdl_q;
        wr_word[1] = stored_ctx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_CLEAR;
      clr_idx    <= '0;
      cur_slot   <= '0;
      probe_cnt  <= '0;
      op_q       <= '0;
      hdl_q      <= '0;
      ctx_q      <= '0;
      rsp_done   <= 1'b0;
      rsp_status <= ST_OK;
      rsp_ctx    <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_CLEAR: begin
          clr_idx <= clr_idx + IDX_W'(1);
          if (clr_idx == '1) state <= S_IDLE;
        end
        S_IDLE: begin
          if (cmd_valid) begin
            op_q      <= cmd_op;
            hdl_q     <= cmd_handle;
            ctx_q     <= cmd_ctx;
            cur_slot  <= hash_slot;
            probe_cnt <= '0;
            state     <= S_READ;
          end
        end
        S_READ: state <= S_CMP;
        S_CMP: begin
          if (probe_hit) begin
            rsp_done   <= 1'b1;
            rsp_status <= ST_OK;
            rsp_ctx    <= op_is_lookup ? rd_word[1] : 32'h0;
            state      <= S_IDLE;
          end else if (probe_nxt == ALL_PROBED) begin
            rsp_done   <= 1'b1;
            rsp_status <= op_is_insert ? ST_FULL : ST_MISS;
            rsp_ctx    <= '0;
            state      <= S_IDLE;
          end else begin
            cur_slot  <= cur_slot + IDX_W'(1);
            probe_cnt <= probe_nxt;
            state     <= S_READ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R8: the engine is idle again when it reports completion
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> cmd_ready);

  // R5: only an insert can report a full table
  a_r5_full_insert: assert property (@(posedge clk) disable iff (rst)
    (rsp_done && rsp_status == ST_FULL) |-> (op_q == OP_INSERT));

  // R5 / R4: no command probes more slots than the table holds
  a_r5_probe_bound: assert property (@(posedge clk) disable iff (rst)
    probe_cnt < ALL_PROBED);

  // R1: no command is taken while the table is being zeroed
  a_r1_clear_busy: assert property (@(posedge clk) disable iff (rst)
    (state == S_CLEAR) |-> !cmd_ready);

  // R3 / R7: RAM writes happen only in the clear sweep or a compare step
  a_r3_write_phase: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (state == S_CLEAR || state == S_CMP));

  // R9: latched command stays put while a probe is in flight
  a_r9_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (state == S_READ) |=> ($stable(hdl_q) && $stable(op_q)));

endmodule

// File: tb/objhash_engine_tb_top.sv
module objhash_engine_tb_top;
  localparam int B     = 6;
  localparam int NSLOT = 1 << B;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_handle;
  logic [4:0]  cmd_chan;
  logic [31:0] cmd_ctx;
  logic        rsp_done;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_ctx;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [31:0] mh [NSLOT];
  logic [31:0] mc [NSLOT];

  always #5 clk = ~clk;

  objhash_engine #(.IDX_W(B), .CHAN_W(5), .LEGACY(1'b1)) dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_handle(cmd_handle), .cmd_chan(cmd_chan),
    .cmd_ctx(cmd_ctx), .rsp_done(rsp_done), .rsp_status(rsp_status),
    .rsp_ctx(rsp_ctx)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int unsigned mhash(input logic [31:0] h, input int ch);
    int unsigned acc = 0;
    logic [31:0] t   = h;
    for (int i = 32; i > 0; i -= B) begin
      acc = acc ^ (t & (NSLOT - 1));
      t   = t >> B;
    end
    acc = acc ^ (ch << (B - 4));
    return acc & (NSLOT - 1);
  endfunction

  // Reference model: predicts probe count, status and context, updates table.
  task automatic run_cmd(input logic [1:0] op, input logic [31:0] h,
                         input int ch, input logic [31:0] ctx,
                         input bit junk, input string req);
    int unsigned s     = mhash(h, ch);
    int          k     = NSLOT;
    logic [1:0]  e_st  = (op == 2'b01) ? 2'b10 : 2'b01;
    logic [31:0] e_ctx = 32'h0;
    for (int p = 0; p < NSLOT; p++) begin
      int unsigned idx = (s + p) % NSLOT;
      if (op == 2'b01) begin
        if (!mc[idx][31]) begin
          mh[idx] = h; mc[idx] = ctx | 32'h8000_0000;
          k = p + 1; e_st = 2'b00; break;
        end
      end else if (mc[idx][31] && mh[idx] == h) begin
        k = p + 1; e_st = 2'b00;
        if (op == 2'b10) begin
          mh[idx] = 32'h0; mc[idx] = 32'h0;
        end else begin
          e_ctx = mc[idx];
        end
        break;
      end
    end
    @(negedge clk);
    chk(cmd_ready === 1'b1, {req, " R8 ready before issue"}, 32'(cmd_ready), 32'h1);
    cmd_valid = 1'b1; cmd_op = op; cmd_handle = h;
    cmd_chan = 5'(ch); cmd_ctx = ctx;
    @(negedge clk);
    chk(rsp_done === 1'b0 && cmd_ready === 1'b0, {req, " R8 busy after accept"},
        32'(rsp_done), 32'h0);
    cmd_valid = junk;
    if (junk) begin
      cmd_op = 2'b01; cmd_handle = 32'hDEAD_BEEF; cmd_chan = 5'd0; cmd_ctx = 32'h1;
    end
    for (int c = 1; c <= 2 * k; c++) begin
      @(negedge clk);
      chk(rsp_done === (c == 2 * k), {req, " R8 done timing"},
          32'(rsp_done), 32'(c == 2 * k));
      if (c < 2 * k)
        chk(cmd_ready === 1'b0, {req, " R8 ready low while busy"}, 32'(cmd_ready), 32'h0);
    end
    chk(rsp_status === e_st, {req, " status"}, 32'(rsp_status), 32'(e_st));
    chk(rsp_ctx === e_ctx, {req, " context"}, rsp_ctx, e_ctx);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NSLOT; i++) begin mh[i] = 0; mc[i] = 0; end
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00;
    cmd_handle = 32'h0; cmd_chan = 5'd0; cmd_ctx = 32'h0;
    repeat (3) @(negedge clk);
    chk(rsp_done === 1'b0, "R1 done low in reset", 32'(rsp_done), 32'h0);
    rst = 1'b0;
    for (int c = 1; c <= NSLOT; c++) begin
      @(negedge clk);
      chk(cmd_ready === (c == NSLOT), "R1 clear sweep ready timing",
          32'(cmd_ready), 32'(c == NSLOT));
    end

    // R1 / R6: empty table misses after a full sweep
    run_cmd(2'b00, 32'h0, 0, 32'h0, 1'b0, "R1 R6 lookup on empty table");
    // R3 / R6: basic insert and lookup, live bit forced
    run_cmd(2'b01, 32'h1234_5678, 3, 32'h0000_0ABC, 1'b0, "R3 insert");
    run_cmd(2'b00, 32'h1234_5678, 3, 32'h0, 1'b0, "R6 lookup hit");
    // R2 / R4: three handles that fold to the same slot
    run_cmd(2'b01, 32'h0000_0001, 0, 32'h11, 1'b0, "R2 insert h1");
    run_cmd(2'b01, 32'h0000_0040, 0, 32'h22, 1'b0, "R2 R4 insert collide");
    run_cmd(2'b01, 32'h0000_1000, 0, 32'h33, 1'b0, "R2 R4 insert collide 2");
    run_cmd(2'b00, 32'h0000_1000, 0, 32'h0, 1'b0, "R4 lookup third probe");
    // R2: channel id changes the start slot
    run_cmd(2'b00, 32'h0000_0001, 1, 32'h0, 1'b0, "R2 lookup other channel");
    run_cmd(2'b01, 32'h0000_0001, 1, 32'h44, 1'b0, "R2 insert channel 1");
    run_cmd(2'b00, 32'h0000_0001, 1, 32'h0, 1'b0, "R2 lookup channel 1");
    // R4: wrap from the last slot to slot 0
    run_cmd(2'b01, 32'h0000_003F, 0, 32'h55, 1'b0, "R4 insert last slot");
    run_cmd(2'b01, 32'h0000_0FC0, 0, 32'h66, 1'b0, "R4 insert wraps");
    run_cmd(2'b11, 32'h0000_0FC0, 0, 32'h0, 1'b0, "R4 R6 lookup alt opcode wrap");
    // R7: remove, repeat remove, reach past the hole, reuse hole
    run_cmd(2'b10, 32'h0000_0040, 0, 32'h0, 1'b0, "R7 remove hit");
    run_cmd(2'b00, 32'h0000_0040, 0, 32'h0, 1'b0, "R7 lookup removed");
    run_cmd(2'b00, 32'h0000_1000, 0, 32'h0, 1'b0, "R7 lookup past hole");
    run_cmd(2'b10, 32'h0000_0040, 0, 32'h0, 1'b0, "R7 remove miss");
    run_cmd(2'b01, 32'h0000_0040, 0, 32'h77, 1'b0, "R7 reinsert into hole");
    run_cmd(2'b00, 32'h0000_0040, 0, 32'h0, 1'b0, "R7 lookup reinserted");
    // R9: a command held during busy is ignored
    run_cmd(2'b00, 32'h1234_5678, 3, 32'h0, 1'b1, "R9 lookup with busy stimulus");
    run_cmd(2'b00, 32'hDEAD_BEEF, 0, 32'h0, 1'b0, "R9 ignored insert absent");
    // R5: fill the table, then overflow
    for (int i = 0; i < NSLOT; i++)
      run_cmd(2'b01, 32'h5000_0000 + 32'(i * 7), i % 4, 32'(i), 1'b0, "R5 fill");
    run_cmd(2'b01, 32'h6000_0001, 0, 32'h99, 1'b0, "R5 insert full");
    run_cmd(2'b00, 32'h6000_0001, 0, 32'h0, 1'b0, "R5 rejected entry absent");
    run_cmd(2'b00, 32'h0000_0FC0, 0, 32'h0, 1'b0, "R5 old entry intact");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule